// File: doc/BRIEF.md
# CPU Address Decode Window Unit

This unit is the CPU-side address decoder of a system controller. It holds ten programmable decode windows (four chip-select windows for memory and boot devices, then an I/O window and two memory windows for each of two PCI buses) plus one fixed-size window onto the controller's internal register space. Each decode window is described by a low field, a high field and a remap field, written over a small register bus; the internal window has a single base register.

For every 32-bit CPU address presented on `cpu_addr`, the unit reports in the same cycle whether any window claims it, a one-hot select naming that window, whether the claim came from the window's remap alias rather than its primary range, the offset of the address from the claiming range's base, and the translated address seen by the target. Window bounds use 2 MB granularity. Two fixed reserved address ranges are cut out of every decode window, so no decode window ever claims them.

Register address `reg_addr` is split as index = `reg_addr[5:2]`, kind = `reg_addr[1:0]`. Indices 0 to 3 are the chip-select windows and 4 to 9 the PCI windows (bus 0 I/O, bus 0 memory A, bus 0 memory B, bus 1 I/O, bus 1 memory A, bus 1 memory B). Kind 0 is the low field, 1 the high field, 2 the remap field. Index 15 with kind 0 is the internal-space base register. Every other address reads as zero and ignores writes.

Top module: `cpu_win_decoder`

## Requirements
- R1: After reset every decode window reads low = 0x007F, high = 0x00, remap = 0x07F, so none is enabled, and the internal base reads 0x00DF, placing the internal window at 0x1BE00000.
- R2: Writes keep only the low 15 bits of a low field, 7 bits of a high field, 11 bits of a remap field and 15 bits of the internal base; `reg_rdata` returns the stored value zero-extended, and unmapped register addresses read zero with writes to them having no effect.
- R3: A write to a window's low field also loads that window's remap field with bits 10:0 of the written data.
- R4: A decode window is enabled only when low[6:0] <= high; its primary range starts at low[10:0] × 2 MB and is ((high + 1) − low[6:0]) × 2 MB long, before clipping.
- R5: The remap alias of an enabled window starts at the clipped primary start with bits 31:21 replaced by the remap field, has the clipped primary length, is clipped again, raises `remap_hit`, and gives `xlat_addr` = clipped primary start + offset.
- R6: With reserved ranges A = [0x1E000000, 0x1F100000) and B = [0x1FC00000, 0x1FD00000), a range end inside A or B moves down to that range's start and a range start inside one moves up to that range's end (A before B); no decode window claims a reserved address.
- R7: A range that begins below a reserved range and ends at or above its end is truncated to end at that reserved range's start, A tested before B.
- R8: The internal window is 4 KB long starting at base[10:0] × 2 MB and is never clipped.
- R9: Priority on overlap: the internal window first, then decode windows in ascending index, and within one window its primary range before its remap alias.
- R10: A register write changes decoding from the clock edge that captures it; during the cycle the write is presented, decoding still uses the old value.
- R11: On a hit `win_sel` is one-hot (bit 0 internal, bit i+1 window i), `hit` is 1, `win_offset` is address minus claiming range start, and `xlat_addr` is the address itself for primary and internal hits; on a miss all of `hit`, `remap_hit`, `win_sel`, `win_offset` and `xlat_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address: index in bits 5:2, kind in bits 1:0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Stored value at `reg_addr`, zero-extended |
| cpu_addr | input | 32 | CPU address to decode |
| hit | output | 1 | Some window claims `cpu_addr` |
| remap_hit | output | 1 | The claim comes from a remap alias |
| win_sel | output | 11 | One-hot claiming window, bit 0 internal |
| win_offset | output | 32 | Address minus start of the claiming range |
| xlat_addr | output | 32 | Translated address |

## Verification
The assertions watch, on every cycle, that the select is one-hot or empty and agrees with `hit`, that a remap claim always comes with a decode-window select, that an address inside the internal window always selects it, that no decode window claims a reserved address, and that decoding holds still while neither the address nor the registers move. The exact window bounds, the clipping and span truncation cases, the remap arithmetic, the priority order, the register masking and the one-cycle write latency can only be shown by the bench's address sweeps and edge probes over programmed configurations, compared against an arithmetic model.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  // Granularity of decode windows (2 MB) and width of the base field
  localparam int GRAN   = 21;
  localparam int FLD_W  = 32 - GRAN;
  localparam int LOW_W  = 15;
  localparam int HIGH_W = 7;
  localparam int RMP_W  = FLD_W;

  // Address range with exclusive upper end; 33 bits so an end of 2^32 fits
  typedef struct packed {
    logic [32:0] lo;
    logic [32:0] hi;
  } span_t;

  // Primary range from the low and high fields; empty when disabled
  function automatic span_t prim_span(logic [LOW_W-1:0] low, logic [HIGH_W-1:0] high);
    span_t       s;
    logic [32:0] base;
    logic [32:0] len;
    base = 33'(low[FLD_W-1:0]) << GRAN;
    len  = (33'(high) + 33'd1 - 33'(low[HIGH_W-1:0])) << GRAN;
    if (low[HIGH_W-1:0] <= high) begin
      s.lo = base;
      s.hi = base + len;
    end else begin
      s = '0;
    end
    return s;
  endfunction

  // Cut the two reserved ranges out of a span
  function automatic span_t clip_span(span_t s, logic [32:0] a_lo, logic [32:0] a_hi,
                                      logic [32:0] b_lo, logic [32:0] b_hi);
    logic [32:0] bgn;
    logic [32:0] fin;
    bgn = s.lo;
    fin = s.hi;
    if (fin >= a_lo && fin < a_hi) fin = a_lo;
    if (bgn >= a_lo && bgn < a_hi) bgn = a_hi;
    if (fin >= b_lo && fin < b_hi) fin = b_lo;
    if (bgn >= b_lo && bgn < b_hi) bgn = b_hi;
    if (fin >= a_hi && bgn < a_lo) fin = a_lo;
    if (fin >= b_hi && bgn < b_lo) fin = b_lo;
    return '{lo: bgn, hi: fin};
  endfunction

  // Remap alias: clipped primary start with its upper field replaced
  function automatic span_t remap_span(span_t p, logic [RMP_W-1:0] rmp);
    logic [32:0] len;
    logic [32:0] base;
    len  = (p.hi > p.lo) ? (p.hi - p.lo) : 33'd0;
    base = {1'b0, rmp, p.lo[GRAN-1:0]};
    return '{lo: base, hi: base + len};
  endfunction

  function automatic logic in_span(logic [31:0] a, span_t s);
    return ({1'b0, a} >= s.lo) && ({1'b0, a} < s.hi);
  endfunction

endpackage

// File: rtl/cwd_regfile.sv
module cwd_regfile
  import cwd_pkg::*;
#(
  parameter int               N        = 10,
  parameter int               IDX_W    = 4,
  parameter logic [LOW_W-1:0] LOW_RST  = 15'h007F,
  parameter logic [HIGH_W-1:0] HIGH_RST = 7'h00,
  parameter logic [LOW_W-1:0] ISD_RST  = 15'h00DF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [IDX_W+1:0]              addr,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output logic [N-1:0][LOW_W-1:0]       low_q,
  output logic [N-1:0][HIGH_W-1:0]      high_q,
  output logic [N-1:0][RMP_W-1:0]       rmp_q,
  output logic [LOW_W-1:0]              isd_q
);

  localparam logic [IDX_W-1:0] INT_IDX = {IDX_W{1'b1}};
  localparam logic [1:0] K_LOW  = 2'd0;
  localparam logic [1:0] K_HIGH = 2'd1;
  localparam logic [1:0] K_RMP  = 2'd2;

  logic [IDX_W-1:0] idx;
  logic [1:0]       kind;
  logic             isd_sel;

  assign idx     = addr[IDX_W+1:2];
  assign kind    = addr[1:0];
  assign isd_sel = (idx == INT_IDX) && (kind == K_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isd_q <= ISD_RST;
      for (int i = 0; i < N; i++) begin
        low_q[i]  <= LOW_RST;
        high_q[i] <= HIGH_RST;
        rmp_q[i]  <= LOW_RST[RMP_W-1:0];
      end
    end else if (wr) begin
      if (isd_sel) isd_q <= wdata[LOW_W-1:0];
      for (int i = 0; i < N; i++) begin
        if (idx == IDX_W'(i)) begin
          case (kind)
            K_LOW: begin
              low_q[i] <= wdata[LOW_W-1:0];
              rmp_q[i] <= wdata[RMP_W-1:0];
            end
            K_HIGH:  high_q[i] <= wdata[HIGH_W-1:0];
            K_RMP:   rmp_q[i]  <= wdata[RMP_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (isd_sel) rdata = 32'(isd_q);
    for (int i = 0; i < N; i++) begin
      if (idx == IDX_W'(i)) begin
        case (kind)
          K_LOW:   rdata = 32'(low_q[i]);
          K_HIGH:  rdata = 32'(high_q[i]);
          K_RMP:   rdata = 32'(rmp_q[i]);
          default: rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/cwd_span_calc.sv
module cwd_span_calc
  import cwd_pkg::*;
#(
  parameter int          N        = 10,
  parameter logic [31:0] RSV0_LO  = 32'h1E00_0000,
  parameter logic [31:0] RSV0_END = 32'h1F10_0000,
  parameter logic [31:0] RSV1_LO  = 32'h1FC0_0000,
  parameter logic [31:0] RSV1_END = 32'h1FD0_0000
) (
  input  logic [N-1:0][LOW_W-1:0]  low_q,
  input  logic [N-1:0][HIGH_W-1:0] high_q,
  input  logic [N-1:0][RMP_W-1:0]  rmp_q,
  output span_t [N-1:0]            prim,
  output span_t [N-1:0]            alias_s
);

  localparam logic [32:0] A_LO = {1'b0, RSV0_LO};
  localparam logic [32:0] A_HI = {1'b0, RSV0_END};
  localparam logic [32:0] B_LO = {1'b0, RSV1_LO};
  localparam logic [32:0] B_HI = {1'b0, RSV1_END};

  for (genvar i = 0; i < N; i++) begin : g_win
    span_t raw_p;
    assign raw_p      = prim_span(low_q[i], high_q[i]);
    assign prim[i]    = clip_span(raw_p, A_LO, A_HI, B_LO, B_HI);
    assign alias_s[i] = clip_span(remap_span(prim[i], rmp_q[i]), A_LO, A_HI, B_LO, B_HI);
  end

endmodule

// File: rtl/cwd_priority.sv
module cwd_priority
  import cwd_pkg::*;
#(
  parameter int N       = 10,
  parameter int INT_LEN = 4096
) (
  input  logic [31:0]       cpu_addr,
  input  logic [LOW_W-1:0]  isd_q,
  input  span_t [N-1:0]     prim,
  input  span_t [N-1:0]     alias_s,
  output logic              int_match,
  output logic [N-1:0]      prim_match,
  output logic [N-1:0]      alias_match,
  output logic              hit,
  output logic              remap_hit,
  output logic [N:0]        win_sel,
  output logic [31:0]       win_offset,
  output logic [31:0]       xlat_addr
);

  logic [32:0] int_base;

  assign int_base  = 33'(isd_q[FLD_W-1:0]) << GRAN;
  assign int_match = ({1'b0, cpu_addr} >= int_base) &&
                     ({1'b0, cpu_addr} < int_base + 33'(INT_LEN));

  for (genvar i = 0; i < N; i++) begin : g_m
    assign prim_match[i]  = in_span(cpu_addr, prim[i]);
    assign alias_match[i] = in_span(cpu_addr, alias_s[i]);
  end

  // Any-claim flag computed apart from the priority chain
  assign hit = int_match | (|prim_match) | (|alias_match);

  always_comb begin
    win_sel    = '0;
    remap_hit  = 1'b0;
    win_offset = '0;
    xlat_addr  = '0;
    // Walk from the weakest claim up so the strongest is written last
    for (int i = N - 1; i >= 0; i--) begin
      if (prim_match[i]) begin
        win_sel      = '0;
        win_sel[i+1] = 1'b1;
        remap_hit    = 1'b0;
        win_offset   = cpu_addr - prim[i].lo[31:0];
        xlat_addr    = cpu_addr;
      end else if (alias_match[i]) begin
        win_sel      = '0;
        win_sel[i+1] = 1'b1;
        remap_hit    = 1'b1;
        win_offset   = cpu_addr - alias_s[i].lo[31:0];
        xlat_addr    = prim[i].lo[31:0] + (cpu_addr - alias_s[i].lo[31:0]);
      end
    end
    if (int_match) begin
      win_sel    = '0;
      win_sel[0] = 1'b1;
      remap_hit  = 1'b0;
      win_offset = cpu_addr - int_base[31:0];
      xlat_addr  = cpu_addr;
    end
  end

endmodule

// File: rtl/cpu_win_decoder.sv
module cpu_win_decoder
  import cwd_pkg::*;
#(
  parameter int          NUM_CS   = 4,
  parameter int          NUM_PCI  = 6,
  parameter int          INT_LEN  = 4096,
  parameter logic [31:0] RSV0_LO  = 32'h1E00_0000,
  parameter logic [31:0] RSV0_END = 32'h1F10_0000,
  parameter logic [31:0] RSV1_LO  = 32'h1FC0_0000,
  parameter logic [31:0] RSV1_END = 32'h1FD0_0000,
  localparam int         NUM_WIN  = NUM_CS + NUM_PCI,
  localparam int         IDX_W    = $clog2(NUM_WIN + 1),
  localparam int         REG_AW   = IDX_W + 2,
  localparam int         SEL_W    = NUM_WIN + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       cpu_addr,
  output logic              hit,
  output logic              remap_hit,
  output logic [SEL_W-1:0]  win_sel,
  output logic [31:0]       win_offset,
  output logic [31:0]       xlat_addr
);

  logic [NUM_WIN-1:0][LOW_W-1:0]  low_q;
  logic [NUM_WIN-1:0][HIGH_W-1:0] high_q;
  logic [NUM_WIN-1:0][RMP_W-1:0]  rmp_q;
  logic [LOW_W-1:0]               isd_q;
  span_t [NUM_WIN-1:0]            prim;
  span_t [NUM_WIN-1:0]            alias_s;
  logic                           int_match;
  logic [NUM_WIN-1:0]             prim_match;
  logic [NUM_WIN-1:0]             alias_match;

  cwd_regfile #(
    .N     (NUM_WIN),
    .IDX_W (IDX_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .low_q  (low_q),
    .high_q (high_q),
    .rmp_q  (rmp_q),
    .isd_q  (isd_q)
  );

  cwd_span_calc #(
    .N        (NUM_WIN),
    .RSV0_LO  (RSV0_LO),
    .RSV0_END (RSV0_END),
    .RSV1_LO  (RSV1_LO),
    .RSV1_END (RSV1_END)
  ) u_span (
    .low_q   (low_q),
    .high_q  (high_q),
    .rmp_q   (rmp_q),
    .prim    (prim),
    .alias_s (alias_s)
  );

  cwd_priority #(
    .N       (NUM_WIN),
    .INT_LEN (INT_LEN)
  ) u_prio (
    .cpu_addr    (cpu_addr),
    .isd_q       (isd_q),
    .prim        (prim),
    .alias_s     (alias_s),
    .int_match   (int_match),
    .prim_match  (prim_match),
    .alias_match (alias_match),
    .hit         (hit),
    .remap_hit   (remap_hit),
    .win_sel     (win_sel),
    .win_offset  (win_offset),
    .xlat_addr   (xlat_addr)
  );

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
  parameter int          SEL_W    = 11,
  parameter int          GRAN     = 21,
  parameter int          ISD_W    = 15,
  parameter logic [31:0] RSV0_LO  = 32'h1E00_0000,
  parameter logic [31:0] RSV0_END = 32'h1F10_0000,
  parameter logic [31:0] RSV1_LO  = 32'h1FC0_0000,
  parameter logic [31:0] RSV1_END = 32'h1FD0_0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [31:0]      cpu_addr,
  input logic             hit,
  input logic             remap_hit,
  input logic [SEL_W-1:0] win_sel,
  input logic [ISD_W-1:0] isd_q
);

  localparam int FW = 32 - GRAN;

  logic in_rsv;
  logic in_int;

  assign in_rsv = (cpu_addr >= RSV0_LO && cpu_addr < RSV0_END) ||
                  (cpu_addr >= RSV1_LO && cpu_addr < RSV1_END);
  assign in_int = (cpu_addr >> 12) == (32'(isd_q[FW-1:0]) << (GRAN - 12));

  assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_sel));

  assert_hit_agrees_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hit == (win_sel != '0));

  assert_remap_is_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    remap_hit |-> (hit && !win_sel[0]));

  assert_internal_claims_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_int |-> win_sel[0]);

  assert_reserved_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rsv && !win_sel[0]) |-> !hit);

  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_wr) && $stable(cpu_addr)) |-> $stable(win_sel));

endmodule

bind cpu_win_decoder cwd_checker #(
  .SEL_W    (SEL_W),
  .RSV0_LO  (RSV0_LO),
  .RSV0_END (RSV0_END),
  .RSV1_LO  (RSV1_LO),
  .RSV1_END (RSV1_END)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .cpu_addr  (cpu_addr),
  .hit       (hit),
  .remap_hit (remap_hit),
  .win_sel   (win_sel),
  .isd_q     (isd_q)
);

// File: tb/test_cpu_win_decoder.sv
module test_cpu_win_decoder;

  localparam int     NW  = 10;
  localparam longint MB2 = 64'd2097152;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] cpu_addr = '0;
  logic        hit;
  logic        remap_hit;
  logic [NW:0] win_sel;
  logic [31:0] win_offset;
  logic [31:0] xlat_addr;

  int n_chk = 0;
  int n_bad = 0;

  longint m_low[NW];
  longint m_high[NW];
  longint m_rm[NW];
  longint m_isd;

  always #4 clk = ~clk;

  cpu_win_decoder i_cpu_win_decoder (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
    .hit(hit), .remap_hit(remap_hit), .win_sel(win_sel),
    .win_offset(win_offset), .xlat_addr(xlat_addr)
  );

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  // ---- reference model, written from the requirements ----
  function automatic void clip(inout longint b, inout longint e);
    longint rl[2] = '{64'h1E00_0000, 64'h1FC0_0000};
    longint rh[2] = '{64'h1F10_0000, 64'h1FD0_0000};
    for (int k = 0; k < 2; k++) begin
      if (e >= rl[k] && e < rh[k]) e = rl[k];
      if (b >= rl[k] && b < rh[k]) b = rh[k];
    end
    for (int k = 0; k < 2; k++)
      if (e >= rh[k] && b < rl[k]) e = rl[k];
  endfunction

  function automatic void prim_b(int i, output longint b, output longint e);
    longint l7 = m_low[i] % 128;
    if (l7 > m_high[i]) begin b = 0; e = 0; return; end
    b = (m_low[i] % 2048) * MB2;
    e = b + (m_high[i] + 1 - l7) * MB2;
    clip(b, e);
  endfunction

  function automatic void alias_b(int i, output longint b, output longint e);
    longint pb, pe, len;
    prim_b(i, pb, pe);
    len = (pe > pb) ? pe - pb : 0;
    b = m_rm[i] * MB2 + (pb % MB2);
    e = b + len;
    clip(b, e);
  endfunction

  task automatic expect_at(longint a, output logic eh, output logic er,
                           output logic [NW:0] es, output longint eo, output longint ex);
    longint ib = (m_isd % 2048) * MB2;
    eh = 0; er = 0; es = '0; eo = 0; ex = 0;
    if (a >= ib && a < ib + 4096) begin
      eh = 1; es[0] = 1'b1; eo = a - ib; ex = a; return;
    end
    for (int i = 0; i < NW; i++) begin
      longint b, e, ab, ae;
      prim_b(i, b, e);
      alias_b(i, ab, ae);
      if (a >= b && a < e) begin
        eh = 1; es[i+1] = 1'b1; eo = a - b; ex = a; return;
      end
      if (a >= ab && a < ae) begin
        eh = 1; er = 1; es[i+1] = 1'b1; eo = a - ab; ex = (b + a - ab) % 64'h1_0000_0000; return;
      end
    end
  endtask

  task automatic check_addr(longint a, string tag);
    logic eh, er; logic [NW:0] es; longint eo, ex;
    if (a < 0 || a > 64'hFFFF_FFFF) return;
    cpu_addr = a[31:0];
    #1;
    expect_at(a, eh, er, es, eo, ex);
    n_chk++;
    if (hit !== eh || remap_hit !== er || win_sel !== es ||
        win_offset !== eo[31:0] || xlat_addr !== ex[31:0]) begin
      n_bad++;
      $display("FAIL %s addr=%h: actual hit=%b rh=%b sel=%b off=%h x=%h expected hit=%b rh=%b sel=%b off=%h x=%h",
               tag, a[31:0], hit, remap_hit, win_sel, win_offset, xlat_addr,
               eh, er, es, eo[31:0], ex[31:0]);
    end
  endtask

  task automatic sweep(string tag);
    for (longint a = 0; a < 64'h1_0000_0000; a += 64'h80000) check_addr(a, tag);
  endtask

  task automatic probe_edges(string tag);
    for (int i = 0; i < NW; i++) begin
      longint b, e;
      prim_b(i, b, e);
      check_addr(b - 1, tag); check_addr(b, tag); check_addr(e - 1, tag); check_addr(e, tag);
      alias_b(i, b, e);
      check_addr(b - 1, tag); check_addr(b, tag); check_addr(e - 1, tag); check_addr(e, tag);
    end
  endtask

  task automatic reg_write(int idx, int kind, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {idx[3:0], kind[1:0]}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (idx == 15 && kind == 0) m_isd = d & 32'h7FFF;
    else if (idx < NW) begin
      if (kind == 0) begin m_low[idx] = d & 32'h7FFF; m_rm[idx] = d & 32'h7FF; end
      else if (kind == 1) m_high[idx] = d & 32'h7F;
      else if (kind == 2) m_rm[idx] = d & 32'h7FF;
    end
  endtask

  task automatic check_read(int idx, int kind, logic [31:0] exp, string tag);
    reg_addr = {idx[3:0], kind[1:0]};
    #1;
    n_chk++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s read idx=%0d kind=%0d: actual %h expected %h", tag, idx, kind, reg_rdata, exp);
    end
  endtask

  task automatic check_sel(logic [NW:0] exp, string tag);
    n_chk++;
    if (win_sel !== exp) begin
      n_bad++;
      $display("FAIL %s: actual sel=%b expected sel=%b", tag, win_sel, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin m_low[i] = 'h7F; m_high[i] = 0; m_rm[i] = 'h7F; end
    m_isd = 'hDF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values and reset decoding
    for (int i = 0; i < NW; i++) begin
      check_read(i, 0, 32'h7F, "R1");
      check_read(i, 1, 32'h0, "R1");
      check_read(i, 2, 32'h7F, "R1");
    end
    check_read(15, 0, 32'hDF, "R1");
    check_addr(64'h1BE0_0000, "R1");
    check_addr(64'h1BE0_0FFF, "R8");
    check_addr(64'h1BE0_1000, "R8");
    check_addr(64'h1BDF_FFFF, "R8");
    sweep("R1");

    // R2: masking and unmapped addresses
    reg_write(9, 0, 32'hFFFF_FFFF);
    check_read(9, 0, 32'h7FFF, "R2");
    check_read(9, 2, 32'h7FF, "R3");
    reg_write(9, 1, 32'hFFFF_FFFF);
    check_read(9, 1, 32'h7F, "R2");
    reg_write(9, 2, 32'hFFFF_F123);
    check_read(9, 2, 32'h123, "R2");
    reg_write(12, 0, 32'h1234_5678);
    check_read(12, 0, 32'h0, "R2");
    reg_write(9, 3, 32'h1234_5678);
    check_read(9, 3, 32'h0, "R2");
    check_read(9, 0, 32'h7FFF, "R2");
    reg_write(15, 0, 32'hFFFF_00DF);
    check_read(15, 0, 32'h00DF, "R2");
    reg_write(9, 0, 32'h7F); reg_write(9, 1, 0);

    // R3 and R4: plain windows, low write reloads remap
    reg_write(0, 2, 32'h155);
    reg_write(0, 0, 32'h0000);
    check_read(0, 2, 32'h000, "R3");
    reg_write(0, 1, 32'h03);
    reg_write(1, 0, 32'hFFFF_8008);
    check_read(1, 0, 32'h0008, "R2");
    check_read(1, 2, 32'h008, "R3");
    reg_write(1, 1, 32'h0F);
    reg_write(8, 0, 32'h05); reg_write(8, 1, 32'h02);   // disabled
    reg_write(2, 0, 32'h7C0); reg_write(2, 1, 32'h40);  // start 0xF8000000, 2 MB
    probe_edges("R4");

    // R6 and R7: clipping
    reg_write(4, 0, 32'hF0); reg_write(4, 1, 32'h78);   // start inside A
    reg_write(5, 0, 32'hE8); reg_write(5, 1, 32'h7F);   // spans A
    reg_write(6, 0, 32'hFA); reg_write(6, 1, 32'h7F);   // end past B, start between
    reg_write(3, 0, 32'hF7); reg_write(3, 1, 32'h7F);   // spans B, ends 0x20000000
    probe_edges("R6");
    check_addr(64'h1E00_0000, "R7");
    check_addr(64'h1DFF_FFFF, "R7");
    check_addr(64'h1F10_0000, "R6");
    check_addr(64'h1FC0_0000, "R6");
    check_addr(64'h1FD0_0000, "R6");

    // R5: remap aliases
    reg_write(0, 2, 32'h100);
    reg_write(4, 2, 32'h200);                           // alias keeps low start bits
    reg_write(7, 0, 32'h10); reg_write(7, 1, 32'h11); reg_write(7, 2, 32'h7FF);
    probe_edges("R5");

    // R9: overlaps
    reg_write(9, 0, 32'h00); reg_write(9, 1, 32'h7F);   // covers CS0 and CS1
    reg_write(7, 2, 32'h000);                           // alias over window 0
    reg_write(15, 0, 32'h01);                           // internal inside window 0 alias area
    check_addr(64'h0020_0000, "R9");
    check_addr(64'h0020_1000, "R9");
    check_addr(64'h0100_0000, "R9");
    probe_edges("R9");
    sweep("R9");

    // R10: write visible only after the capturing edge
    reg_write(15, 0, 32'hDF);
    @(negedge clk);
    cpu_addr = 32'h2000_0000;
    reg_wr = 1'b1; reg_addr = {4'd15, 2'd0}; reg_wdata = 32'h100;
    #1;
    check_sel(11'b000_0000_0010, "R10");
    @(negedge clk);
    reg_wr = 1'b0;
    m_isd = 'h100;
    #1;
    check_sel(11'b000_0000_0001, "R10");
    check_addr(64'h2000_0FFF, "R10");
    check_addr(64'h2000_1000, "R11");
    check_addr(64'h6000_0000, "R11");
    sweep("R11");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule